// File: doc/BRIEF.md
# Cache Tag Statistics Engine

This block models the hit and miss behaviour of a data cache by keeping only tags and per-line state, never the data. Accesses arrive one at a time over a valid/ready handshake. Each carries a load/store flag and a 32-bit byte address. The block looks the address up in the indexed set, updates valid, dirty and replacement state, and accumulates seven counters: loads, stores, load hits, load misses, store hits, store misses and total cycles.

The geometry is fixed at elaboration: the number of sets, ways per set and bytes per block, each a power of two. One set gives a fully associative cache. One way gives a direct-mapped cache. The smallest legal geometry is one set, one way and four bytes. The write-allocate choice, the write-through choice and the replacement policy (least recently used or first in, first out) are run-time inputs.

The cycle counter charges 1 cycle for every access that touches the cache. It charges 100 cycles for each 4-byte word moved to or from memory. A synchronous clear empties the cache model and zeroes every counter.

Top module: `cache_tag_stats`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, all seven counters read 0 and every line is invalid. An access made afterwards to a previously cached block is counted as a miss.
- R2: The address is split into three fields. The low log2(BLOCK_BYTES) bits are the byte offset. The next log2(SETS) bits select the set. The remaining upper bits form the tag. A load to a different offset within a resident block is a load hit and adds 1 cycle.
- R3: A load that matches no valid way of its set is a load miss. It fills a way and adds 1 + 100*(BLOCK_BYTES/4) cycles, plus any dirty-victim cost from R8.
- R4: When `cfg_lru` is 1, hits and fills both mark a way most recent. A fill into a full set evicts the least recently used way.
- R5: When `cfg_lru` is 0, only fills update the order. A fill into a full set evicts the way filled earliest, even if that way was hit more recently.
- R6: A store miss with `cfg_wr_alloc`=0 writes memory only. It adds 100 cycles, counts as a store miss, and leaves the cache unchanged, so a following load to that block misses.
- R7: With `cfg_wr_thru`=1, every store that is hit or allocated costs an extra 100 cycles and leaves the line clean. A store hit therefore costs 101 cycles.
- R8: With `cfg_wr_thru`=0, a store hit costs 1 cycle and marks the line dirty. Evicting a dirty line adds 100*(BLOCK_BYTES/4) cycles. Evicting a clean line adds nothing.
- R9: The cycle counter grows only in the cycle after an accepted access, by exactly the sum of the costs in R2 to R8.
- R10: `cfg_err` is 1 exactly when `cfg_wr_alloc`=0 and `cfg_wr_thru`=0. While it is 1, `acc_ready` is 0, no access is taken and no counter changes.
- R11: After an access is accepted, `acc_ready` is 0 for one cycle while the tags update. It returns to 1 in the following cycle.
- R12: Invalid ways fill before any valid way is evicted, lowest-numbered invalid way first. Each fill counts as a miss and each hit counts as a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of lines and counters |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Block can take an access |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Byte address |
| cfg_wr_alloc | input | 1 | 1 = store misses allocate |
| cfg_wr_thru | input | 1 | 1 = write-through, 0 = write-back |
| cfg_lru | input | 1 | 1 = LRU replacement, 0 = FIFO |
| cfg_err | output | 1 | Illegal policy combination |
| cnt_loads | output | CNT_W | Total loads |
| cnt_stores | output | CNT_W | Total stores |
| cnt_ld_hit | output | CNT_W | Load hits |
| cnt_ld_miss | output | CNT_W | Load misses |
| cnt_st_hit | output | CNT_W | Store hits |
| cnt_st_miss | output | CNT_W | Store misses |
| cnt_cycles | output | CNT_W | Total cycles |

## Verification
The bench builds the block with 4 sets, 2 ways and 8-byte blocks. Each fill or dirty writeback then costs 200 cycles, and addresses 0x100, 0x200 and 0x300 all map to set 0 with distinct tags. Three tags competing for two ways make the LRU and FIFO victim choices visible at the counters, and dirty and clean evictions separate by exactly one block's cost. Other sets serve the write-through and no-allocate cases without disturbing that set.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int unsigned WORD_BYTES      = 4;
  localparam int unsigned MEM_WORD_CYCLES = 100;

  // outcome of one looked-up access
  typedef struct packed {
    logic is_store;
    logic hit;
    logic fill;
    logic wb_evict;
    logic thru;
  } cts_event_t;
endpackage

// File: rtl/cts_match.sv
module cts_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  parameter int WW    = 2
) (
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]            set_valid,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       hit,
  output logic [WW-1:0]              hit_way
);
  logic [WAYS-1:0] eq;

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_cmp
    assign eq[gw] = set_valid[gw] && (set_tags[gw] == req_tag);
  end

  always_comb begin
    hit     = |eq;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) hit_way = WW'(w);
    end
  end
endmodule

// File: rtl/cts_victim.sv
module cts_victim #(
  parameter int WAYS = 4,
  parameter int WW   = 2
) (
  input  logic [WAYS-1:0]         set_valid,
  input  logic [WAYS-1:0][WW-1:0] set_rank,
  output logic [WW-1:0]           victim
);
  logic [WW-1:0] oldest;
  logic [WW-1:0] free_way;
  logic          any_free;

  always_comb begin
    oldest = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (set_rank[w] == WW'(WAYS - 1)) oldest = WW'(w);
    end
    free_way = '0;
    any_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_valid[w]) begin
        free_way = WW'(w);
        any_free = 1'b1;
      end
    end
    victim = any_free ? free_way : oldest;
  end
endmodule

// File: rtl/cts_rank.sv
module cts_rank #(
  parameter int WAYS = 4,
  parameter int WW   = 2
) (
  input  logic [WAYS-1:0][WW-1:0] rank_cur,
  input  logic                    touch_en,
  input  logic [WW-1:0]           touch_way,
  output logic [WAYS-1:0][WW-1:0] rank_nxt
);
  logic [WW-1:0] touched_rank;
  assign touched_rank = rank_cur[touch_way];

  // rank 0 = newest; ways newer than the touched one age by one
  for (genvar gw = 0; gw < WAYS; gw++) begin : g_rank
    always_comb begin
      if (!touch_en) begin
        rank_nxt[gw] = rank_cur[gw];
      end else if (touch_way == WW'(gw)) begin
        rank_nxt[gw] = '0;
      end else if (rank_cur[gw] < touched_rank) begin
        rank_nxt[gw] = rank_cur[gw] + WW'(1);
      end else begin
        rank_nxt[gw] = rank_cur[gw];
      end
    end
  end
endmodule

// File: rtl/cts_stats.sv
module cts_stats
  import cts_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int BLOCK_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev_en,
  input  cts_event_t       ev,
  output logic [CNT_W-1:0] cnt_loads,
  output logic [CNT_W-1:0] cnt_stores,
  output logic [CNT_W-1:0] cnt_ld_hit,
  output logic [CNT_W-1:0] cnt_ld_miss,
  output logic [CNT_W-1:0] cnt_st_hit,
  output logic [CNT_W-1:0] cnt_st_miss,
  output logic [CNT_W-1:0] cnt_cycles
);
  localparam int unsigned BLOCK_CYC = (BLOCK_BYTES / WORD_BYTES) * MEM_WORD_CYCLES;

  logic [CNT_W-1:0] loads_n, stores_n, ld_hit_n, ld_miss_n, st_hit_n, st_miss_n, cycles_n;
  logic [CNT_W-1:0] cost;

  always_comb begin
    cost = '0;
    if (ev.hit || ev.fill)          cost = cost + CNT_W'(1);
    if (ev.fill)                    cost = cost + CNT_W'(BLOCK_CYC);
    if (ev.wb_evict)                cost = cost + CNT_W'(BLOCK_CYC);
    if (ev.is_store && ev.thru)     cost = cost + CNT_W'(MEM_WORD_CYCLES);

    loads_n   = cnt_loads;
    stores_n  = cnt_stores;
    ld_hit_n  = cnt_ld_hit;
    ld_miss_n = cnt_ld_miss;
    st_hit_n  = cnt_st_hit;
    st_miss_n = cnt_st_miss;
    cycles_n  = cnt_cycles;
    if (clr) begin
      loads_n = '0; stores_n = '0; ld_hit_n = '0; ld_miss_n = '0;
      st_hit_n = '0; st_miss_n = '0; cycles_n = '0;
    end else if (ev_en) begin
      cycles_n = cnt_cycles + cost;
      if (ev.is_store) begin
        stores_n = cnt_stores + CNT_W'(1);
        if (ev.hit) st_hit_n  = cnt_st_hit + CNT_W'(1);
        else        st_miss_n = cnt_st_miss + CNT_W'(1);
      end else begin
        loads_n = cnt_loads + CNT_W'(1);
        if (ev.hit) ld_hit_n  = cnt_ld_hit + CNT_W'(1);
        else        ld_miss_n = cnt_ld_miss + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_loads <= '0; cnt_stores <= '0; cnt_ld_hit <= '0; cnt_ld_miss <= '0;
      cnt_st_hit <= '0; cnt_st_miss <= '0; cnt_cycles <= '0;
    end else if (clr || ev_en) begin
      cnt_loads   <= loads_n;
      cnt_stores  <= stores_n;
      cnt_ld_hit  <= ld_hit_n;
      cnt_ld_miss <= ld_miss_n;
      cnt_st_hit  <= st_hit_n;
      cnt_st_miss <= st_miss_n;
      cnt_cycles  <= cycles_n;
    end
  end
endmodule

// File: rtl/cache_tag_stats.sv
module cache_tag_stats
  import cts_pkg::*;
#(
  parameter int SETS        = 16,
  parameter int WAYS        = 4,
  parameter int BLOCK_BYTES = 16,
  parameter int CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic             acc_store,
  input  logic [31:0]      acc_addr,
  input  logic             cfg_wr_alloc,
  input  logic             cfg_wr_thru,
  input  logic             cfg_lru,
  output logic             cfg_err,
  output logic [CNT_W-1:0] cnt_loads,
  output logic [CNT_W-1:0] cnt_stores,
  output logic [CNT_W-1:0] cnt_ld_hit,
  output logic [CNT_W-1:0] cnt_ld_miss,
  output logic [CNT_W-1:0] cnt_st_hit,
  output logic [CNT_W-1:0] cnt_st_miss,
  output logic [CNT_W-1:0] cnt_cycles
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_B = $clog2(SETS);
  localparam int TAG_W = 32 - OFF_W - IDX_B;
  localparam int IW    = (SETS > 1) ? IDX_B : 1;
  localparam int WW    = (WAYS > 1) ? $clog2(WAYS) : 1;

  // request register
  logic             busy_q, busy_n;
  logic             req_store_q;
  logic [31:0]      req_addr_q;
  logic             accept;
  logic             offset_unused;

  // line state
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];
  logic [WAYS-1:0][WW-1:0]    rank_q  [SETS];

  // lookup signals
  logic [IW-1:0]              req_idx;
  logic [TAG_W-1:0]           req_tag;
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0]            set_valid, set_dirty, valid_set_n, dirty_set_n;
  logic [WAYS-1:0][WW-1:0]    set_rank, rank_set_n;
  logic                       hit, fill, wb_evict, touch;
  logic [WW-1:0]              hit_way, victim, way_sel;
  cts_event_t                 ev;

  assign offset_unused = ^acc_addr[OFF_W-1:0];
  assign cfg_err   = !cfg_wr_alloc && !cfg_wr_thru;
  assign acc_ready = !busy_q && !cfg_err;
  assign accept    = acc_valid && acc_ready;
  assign busy_n    = !clr && accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_n;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      req_store_q <= acc_store;
      req_addr_q  <= acc_addr;
    end
  end

  assign req_idx   = IW'((req_addr_q >> OFF_W) & 32'(SETS - 1));
  assign req_tag   = req_addr_q[31 -: TAG_W];
  assign set_tags  = tag_q[req_idx];
  assign set_valid = valid_q[req_idx];
  assign set_dirty = dirty_q[req_idx];
  assign set_rank  = rank_q[req_idx];

  cts_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WW(WW)) u_match (
    .set_tags (set_tags),
    .set_valid(set_valid),
    .req_tag  (req_tag),
    .hit      (hit),
    .hit_way  (hit_way)
  );

  cts_victim #(.WAYS(WAYS), .WW(WW)) u_victim (
    .set_valid(set_valid),
    .set_rank (set_rank),
    .victim   (victim)
  );

  // next-state decision for the looked-up set
  always_comb begin
    way_sel  = hit ? hit_way : victim;
    fill     = busy_q && !hit && (!req_store_q || cfg_wr_alloc);
    wb_evict = fill && set_valid[victim] && set_dirty[victim];
    touch    = busy_q && (cfg_lru ? (hit || fill) : fill);

    valid_set_n = set_valid;
    dirty_set_n = set_dirty;
    if (fill) begin
      valid_set_n[way_sel] = 1'b1;
      dirty_set_n[way_sel] = 1'b0;
    end
    if (busy_q && req_store_q && (hit || fill)) dirty_set_n[way_sel] = !cfg_wr_thru;

    ev.is_store = req_store_q;
    ev.hit      = hit;
    ev.fill     = fill;
    ev.wb_evict = wb_evict;
    ev.thru     = cfg_wr_thru;
  end

  cts_rank #(.WAYS(WAYS), .WW(WW)) u_rank (
    .rank_cur (set_rank),
    .touch_en (touch),
    .touch_way(way_sel),
    .rank_nxt (rank_set_n)
  );

  function automatic logic [WAYS-1:0][WW-1:0] rank_init();
    logic [WAYS-1:0][WW-1:0] r;
    for (int w = 0; w < WAYS; w++) r[w] = WW'(w);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        rank_q[s]  <= rank_init();
      end
    end else if (clr) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        rank_q[s]  <= rank_init();
      end
    end else if (busy_q) begin
      valid_q[req_idx] <= valid_set_n;
      dirty_q[req_idx] <= dirty_set_n;
      rank_q[req_idx]  <= rank_set_n;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) tag_q[req_idx][way_sel] <= req_tag;
  end

  cts_stats #(.CNT_W(CNT_W), .BLOCK_BYTES(BLOCK_BYTES)) u_stats (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .ev_en      (busy_q),
    .ev         (ev),
    .cnt_loads  (cnt_loads),
    .cnt_stores (cnt_stores),
    .cnt_ld_hit (cnt_ld_hit),
    .cnt_ld_miss(cnt_ld_miss),
    .cnt_st_hit (cnt_st_hit),
    .cnt_st_miss(cnt_st_miss),
    .cnt_cycles (cnt_cycles)
  );
endmodule

// File: rtl/cts_checker.sv
module cts_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic             cfg_err,
  input logic [CNT_W-1:0] cnt_loads,
  input logic [CNT_W-1:0] cnt_stores,
  input logic [CNT_W-1:0] cnt_ld_hit,
  input logic [CNT_W-1:0] cnt_ld_miss,
  input logic [CNT_W-1:0] cnt_st_hit,
  input logic [CNT_W-1:0] cnt_st_miss,
  input logic [CNT_W-1:0] cnt_cycles
);
  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready |=> !acc_ready); // R11

  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !acc_ready); // R10

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_loads == '0 && cnt_stores == '0 && cnt_cycles == '0)); // R1

  AST_LOAD_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W+1)'(cnt_ld_hit) + (CNT_W+1)'(cnt_ld_miss) == (CNT_W+1)'(cnt_loads)); // R3

  AST_STORE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W+1)'(cnt_st_hit) + (CNT_W+1)'(cnt_st_miss) == (CNT_W+1)'(cnt_stores)); // R6

  AST_CYCLES_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_cycles) && !$past(clr) |-> !$past(acc_ready)); // R9
endmodule

bind cache_tag_stats cts_checker #(.CNT_W(CNT_W)) u_cts_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .cfg_err    (cfg_err),
  .cnt_loads  (cnt_loads),
  .cnt_stores (cnt_stores),
  .cnt_ld_hit (cnt_ld_hit),
  .cnt_ld_miss(cnt_ld_miss),
  .cnt_st_hit (cnt_st_hit),
  .cnt_st_miss(cnt_st_miss),
  .cnt_cycles (cnt_cycles)
);

// File: tb/test_cache_tag_stats.sv
module test_cache_tag_stats;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 4;
  localparam int NW   = 2;
  localparam int BB   = 8;
  localparam int OB   = 3;
  localparam int IB   = 2;
  localparam int FILL = (BB / 4) * 100;

  logic        clk = 1'b0;
  logic        rst_n, clr, acc_valid, acc_ready, acc_store;
  logic [31:0] acc_addr;
  logic        wa, wt, lru, cfg_err;
  logic [31:0] c_ld, c_st, c_lh, c_lm, c_sh, c_sm, c_cy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cache_tag_stats #(.SETS(NS), .WAYS(NW), .BLOCK_BYTES(BB), .CNT_W(32)) i_cache_tag_stats (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_store(acc_store), .acc_addr(acc_addr), .cfg_wr_alloc(wa), .cfg_wr_thru(wt),
    .cfg_lru(lru), .cfg_err(cfg_err), .cnt_loads(c_ld), .cnt_stores(c_st),
    .cnt_ld_hit(c_lh), .cnt_ld_miss(c_lm), .cnt_st_hit(c_sh), .cnt_st_miss(c_sm),
    .cnt_cycles(c_cy)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit run_cmp = 0;

  // behavioural reference: 0 loads,1 stores,2 ld hit,3 ld miss,4 st hit,5 st miss,6 cycles
  int pend [7];
  int expv [7];
  int req_seq = 0;
  int seen_seq = 0;
  bit mv [NS][NW];
  bit md [NS][NW];
  int unsigned mt [NS][NW];
  int ms [NS][NW];
  int tick = 0;

  always @(posedge clk) begin
    if (req_seq != seen_seq) begin
      for (int k = 0; k < 7; k++) expv[k] <= pend[k];
      seen_seq <= req_seq;
    end
  end

  function automatic int cval(int k);
    case (k)
      0: return int'(c_ld);
      1: return int'(c_st);
      2: return int'(c_lh);
      3: return int'(c_lm);
      4: return int'(c_sh);
      5: return int'(c_sm);
      default: return int'(c_cy);
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  string ctag [7] = '{"R2 loads", "R6 stores", "R4 load hits", "R3 load misses",
                      "R8 store hits", "R6 store misses", "R9 cycles"};

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      for (int k = 0; k < 7; k++) chk({ctag[k], " vs model"}, cval(k), expv[k]);
    end
  end

  task automatic model_reset();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        mv[s][w] = 0; md[s][w] = 0; ms[s][w] = 0; mt[s][w] = 0;
      end
    for (int k = 0; k < 7; k++) pend[k] = 0;
  endtask

  task automatic model_step(bit st, logic [31:0] a);
    int idx;
    int unsigned tg;
    int hw;
    int vw;
    idx = int'((a >> OB) % NS);
    tg  = a >> (OB + IB);
    hw  = -1;
    tick++;
    for (int w = 0; w < NW; w++) if (mv[idx][w] && mt[idx][w] == tg) hw = w;
    if (st) pend[1]++; else pend[0]++;
    if (hw >= 0) begin
      if (st) pend[4]++; else pend[2]++;
      pend[6] += 1;
      if (st) begin
        if (wt) pend[6] += 100; else md[idx][hw] = 1;
      end
      if (lru) ms[idx][hw] = tick;
    end else begin
      if (st) pend[5]++; else pend[3]++;
      if (!st || wa) begin
        vw = -1;
        for (int w = NW - 1; w >= 0; w--) if (!mv[idx][w]) vw = w;
        if (vw < 0) begin
          vw = 0;
          for (int w = 1; w < NW; w++) if (ms[idx][w] < ms[idx][vw]) vw = w;
        end
        if (mv[idx][vw] && md[idx][vw]) pend[6] += FILL;
        mv[idx][vw] = 1; md[idx][vw] = 0; mt[idx][vw] = tg; ms[idx][vw] = tick;
        pend[6] += FILL + 1;
        if (st) begin
          if (wt) pend[6] += 100; else md[idx][vw] = 1;
        end
      end else begin
        pend[6] += 100;
      end
    end
  endtask

  task automatic acc(bit st, logic [31:0] a);
    @(negedge clk);
    acc_valid = 1; acc_store = st; acc_addr = a;
    @(negedge clk);
    acc_valid = 0;
    chk("R11 ready low while busy", int'(acc_ready), 0);
    model_step(st, a);
    req_seq++;
    @(negedge clk);
    chk("R11 ready back after update", int'(acc_ready), 1);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1;
    model_reset();
    req_seq++;
    @(negedge clk);
    clr = 0;
  endtask

  // access then check one counter delta
  task automatic acc_d(bit st, logic [31:0] a, int k, int d, string tag);
    int b;
    b = cval(k);
    acc(st, a);
    chk(tag, cval(k) - b, d);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int b;
    rst_n = 0; clr = 0; acc_valid = 0; acc_store = 0; acc_addr = '0;
    wa = 1; wt = 0; lru = 1;
    model_reset();
    for (int k = 0; k < 7; k++) expv[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    run_cmp = 1;
    @(negedge clk);
    chk("R1 ready after reset", int'(acc_ready), 1);
    for (int k = 0; k < 7; k++) chk("R1 counter zero after reset", cval(k), 0);

    // LRU, write-allocate, write-back; set 0 holds tags of 0x100/0x200/0x300
    acc_d(0, 32'h100, 6, FILL + 1, "R3 load miss cost");
    acc_d(0, 32'h104, 2, 1, "R2 offset hit");
    acc_d(0, 32'h200, 3, 1, "R12 second way fills");
    acc_d(0, 32'h100, 2, 1, "R12 first way kept");
    acc_d(0, 32'h300, 3, 1, "R4 miss into full set");
    acc_d(0, 32'h100, 2, 1, "R4 recent way kept");
    acc_d(0, 32'h200, 3, 1, "R4 evicted way misses");
    acc_d(1, 32'h100, 6, 1, "R8 write-back store hit cost");
    acc_d(0, 32'h300, 6, FILL + 1, "R8 clean eviction cost");
    acc_d(0, 32'h200, 6, 2 * FILL + 1, "R8 dirty eviction cost");

    // clear
    do_clear();
    @(negedge clk);
    for (int k = 0; k < 7; k++) chk("R1 counter zero after clear", cval(k), 0);
    acc_d(0, 32'h200, 3, 1, "R1 lines invalid after clear");

    // FIFO
    lru = 0;
    acc_d(0, 32'h100, 3, 1, "R5 fill second way");
    acc_d(0, 32'h200, 2, 1, "R5 hit oldest");
    acc_d(0, 32'h300, 3, 1, "R5 miss into full set");
    acc_d(0, 32'h100, 2, 1, "R5 newer fill kept");
    acc_d(0, 32'h200, 3, 1, "R5 earliest fill evicted");

    // write-through with allocate
    lru = 1; wt = 1;
    acc_d(1, 32'h508, 6, FILL + 101, "R7 store miss allocate cost");
    acc_d(1, 32'h50C, 6, 101, "R7 store hit cost");
    acc_d(0, 32'h50C, 2, 1, "R7 allocated line hits");

    // no-write-allocate
    wa = 0;
    acc_d(1, 32'h710, 6, 100, "R6 no-allocate store cost");
    acc_d(0, 32'h710, 3, 1, "R6 cache unchanged");

    // write-back store miss with allocate
    wa = 1; wt = 0;
    acc_d(1, 32'h718, 6, FILL + 1, "R8 store miss allocate cost");

    // illegal combination
    @(negedge clk);
    wa = 0; wt = 0;
    @(negedge clk);
    chk("R10 error flag", int'(cfg_err), 1);
    chk("R10 ready held low", int'(acc_ready), 0);
    b = int'(c_st);
    acc_valid = 1; acc_store = 1; acc_addr = 32'h100;
    repeat (3) @(negedge clk);
    acc_valid = 0;
    chk("R10 no access taken", int'(c_st), b);
    wa = 1;
    @(negedge clk);
    chk("R10 error flag clears", int'(cfg_err), 0);
    chk("R10 ready restored", int'(acc_ready), 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule